// File: doc/BRIEF.md
# Trap entry and return sequencer

This block holds the hart's current privilege level and the status bits that trap handling touches. It takes one event at a time: a synchronous exception, an interrupt, a machine-level return or a supervisor-level return. In the clock edge where the event strobe is high it commits every update that the event implies. These updates cover the privilege level, the interrupt-enable bits and their saved copies, the saved previous privilege, and the cause, exception-PC and trap-value registers of the handling level. One cycle later it presents the address that fetch must redirect to.

For a trap, the block first picks the handling level. A delegation mask, indexed by the cause code, may send the event to supervisor level. A trap is never handled below the level it was raised at. The redirect address is that level's vector base, aligned to four bytes. For a return, the redirect address is the saved exception PC with bit 0 cleared. The caller supplies the delegation mask that matches the event, for exceptions or for interrupts. The vector bases come from elsewhere in the core.

Top module: `trap_seq`

## Requirements
- R1: After reset the privilege is machine (encoding 2'b11), the saved machine previous privilege is the lowest supported level (user, 2'b00, by default), every enable, saved-enable, SPP and MPRV bit is 0, all six trap registers are 0, and redirect is low.
- R2: A trap (ev_kind 2'b00) targets supervisor (2'b01) when supervisor level is supported and deleg_mask[ev_code] is 1; otherwise it targets machine.
- R3: When the R2 target is less privileged than the current level, the trap is handled at the current level, so a trap never lowers the privilege.
- R4: A machine-level trap sets mcause to ev_intr in bit XLEN-1 with ev_code zero-extended below it, copies MIE into MPIE, clears MIE, stores the old privilege in MPP, writes mepc with ev_pc and sets the privilege to machine.
- R5: A supervisor-level trap does the same on scause, SPIE, SIE and sepc. SPP becomes 1 when the trap came from supervisor and 0 when it came from user. The privilege becomes supervisor and the machine fields are untouched.
- R6: The handling level's trap-value register takes ev_tval when ev_tval_valid is 1 and 0 otherwise.
- R7: A machine return (ev_kind 2'b01) sets MIE to the old MPIE, sets MPIE to 1, sets the privilege to the old MPP and then sets MPP to user, or to machine when user level is not supported.
- R8: A supervisor return (ev_kind 2'b10) sets SIE to the old SPIE, sets SPIE to 1, sets the privilege to supervisor if SPP was 1 and to user otherwise, and clears SPP.
- R9: mprv_set sets MPRV to 1. After either return, MPRV is 0 when the new privilege is not machine. It keeps its value when the return lands in machine or when the event is a trap.
- R10: One cycle after an event, redirect is 1 for one cycle. next_pc is then the target level's vector base with bits 1:0 cleared for a trap, or the old mepc (machine return) or sepc (supervisor return) with bit 0 cleared.
- R11: With ev_valid low, or with ev_kind 2'b11, no state changes and redirect stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe; all updates commit at this edge |
| ev_kind | input | 2 | 00 trap, 01 machine return, 10 supervisor return, 11 none |
| ev_intr | input | 1 | Trap is an interrupt |
| ev_code | input | CODE_W | Cause code |
| ev_pc | input | XLEN | PC of the trapping instruction |
| ev_tval_valid | input | 1 | ev_tval carries a value |
| ev_tval | input | XLEN | Trap value |
| deleg_mask | input | 2**CODE_W | Per-cause delegation bits |
| mtvec_base | input | XLEN | Machine vector base |
| stvec_base | input | XLEN | Supervisor vector base |
| mprv_set | input | 1 | Sets MPRV |
| priv | output | 2 | Current privilege |
| st_mie | output | 1 | Machine interrupt enable |
| st_mpie | output | 1 | Saved machine enable |
| st_mpp | output | 2 | Saved machine previous privilege |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_spie | output | 1 | Saved supervisor enable |
| st_spp | output | 1 | Saved supervisor previous privilege |
| st_mprv | output | 1 | Modify-privilege bit |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| redirect | output | 1 | next_pc is valid this cycle |
| next_pc | output | XLEN | Fetch redirect address |

## Verification
Two states are hard to reach from the ports. The first is a supervisor return that lands in supervisor. It needs SPP at 1, so the bench must trap into supervisor while already running there, which calls for an earlier delegated trap from user. The second is a machine return that lands in machine with MPRV set. It needs a trap taken from machine so that MPP holds machine. The stimulus table walks a single chain of events from reset through these states. Each row expects the status the previous rows built up, so a wrong save or restore order shows up several rows later as well. Directed tests then cover the MPRV and ignored-event cases.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        EV_TRAP = 2'b00,
        EV_MRET = 2'b01,
        EV_SRET = 2'b10,
        EV_NONE = 2'b11
    } ev_e;

endpackage

// File: rtl/trap_tgt_sel.sv
module trap_tgt_sel
    import trap_seq_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter bit HAS_S  = 1'b1
) (
    input  logic [1:0]             cur_priv,
    input  logic [CODE_W-1:0]      code,
    input  logic [2**CODE_W-1:0]   mask,
    output logic [1:0]             tgt_priv,
    output logic                   tgt_is_s
);
    logic       delegate;
    logic [1:0] cand;

    always_comb begin
        delegate = HAS_S && mask[code];
        cand     = delegate ? PRIV_S : PRIV_M;
        // never drop below the level the trap was raised at
        tgt_priv = (cand < cur_priv) ? cur_priv : cand;
        tgt_is_s = (tgt_priv == PRIV_S);
    end

endmodule

// File: rtl/trap_vec_sel.sv
module trap_vec_sel
    import trap_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      kind,
    input  logic            tgt_is_s,
    input  logic [XLEN-1:0] mtvec_base,
    input  logic [XLEN-1:0] stvec_base,
    input  logic [XLEN-1:0] mepc_cur,
    input  logic [XLEN-1:0] sepc_cur,
    output logic [XLEN-1:0] pc_out
);
    localparam logic [XLEN-1:0] VEC_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};
    localparam logic [XLEN-1:0] RET_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (kind)
            EV_MRET: pc_out = mepc_cur & RET_MASK;
            EV_SRET: pc_out = sepc_cur & RET_MASK;
            default: pc_out = (tgt_is_s ? stvec_base : mtvec_base) & VEC_MASK;
        endcase
    end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5,
    parameter bit HAS_S  = 1'b1,
    parameter bit HAS_U  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [1:0]            ev_kind,
    input  logic                  ev_intr,
    input  logic [CODE_W-1:0]     ev_code,
    input  logic [XLEN-1:0]       ev_pc,
    input  logic                  ev_tval_valid,
    input  logic [XLEN-1:0]       ev_tval,
    input  logic [2**CODE_W-1:0]  deleg_mask,
    input  logic [XLEN-1:0]       mtvec_base,
    input  logic [XLEN-1:0]       stvec_base,
    input  logic                  mprv_set,
    output logic [1:0]            priv,
    output logic                  st_mie,
    output logic                  st_mpie,
    output logic [1:0]            st_mpp,
    output logic                  st_sie,
    output logic                  st_spie,
    output logic                  st_spp,
    output logic                  st_mprv,
    output logic [XLEN-1:0]       mcause,
    output logic [XLEN-1:0]       mepc,
    output logic [XLEN-1:0]       mtval,
    output logic [XLEN-1:0]       scause,
    output logic [XLEN-1:0]       sepc,
    output logic [XLEN-1:0]       stval,
    output logic                  redirect,
    output logic [XLEN-1:0]       next_pc
);
    localparam int         PAD_W   = XLEN - 1 - CODE_W;
    localparam logic [1:0] LOW_PRV = HAS_U ? PRIV_U : PRIV_M;

    typedef struct packed {
        logic [1:0]      prv;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic            sie;
        logic            spie;
        logic            spp;
        logic            mprv;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mtval;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] stval;
        logic            redir;
        logic [XLEN-1:0] npc;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]      tgt_priv;
    logic            tgt_is_s;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] cause_val;
    logic [XLEN-1:0] tval_val;

    trap_tgt_sel #(
        .CODE_W (CODE_W),
        .HAS_S  (HAS_S)
    ) u_tgt (
        .cur_priv (st_q.prv),
        .code     (ev_code),
        .mask     (deleg_mask),
        .tgt_priv (tgt_priv),
        .tgt_is_s (tgt_is_s)
    );

    trap_vec_sel #(
        .XLEN (XLEN)
    ) u_vec (
        .kind       (ev_kind),
        .tgt_is_s   (tgt_is_s),
        .mtvec_base (mtvec_base),
        .stvec_base (stvec_base),
        .mepc_cur   (st_q.mepc),
        .sepc_cur   (st_q.sepc),
        .pc_out     (tgt_pc)
    );

    always_comb begin
        cause_val = {ev_intr, {PAD_W{1'b0}}, ev_code};
        tval_val  = ev_tval_valid ? ev_tval : '0;

        st_d       = st_q;
        st_d.redir = 1'b0;
        st_d.mprv  = st_q.mprv | mprv_set;

        if (ev_valid) begin
            unique case (ev_kind)
                EV_TRAP: begin
                    st_d.redir = 1'b1;
                    st_d.npc   = tgt_pc;
                    if (tgt_is_s) begin
                        st_d.scause = cause_val;
                        st_d.spie   = st_q.sie;
                        st_d.sie    = 1'b0;
                        st_d.spp    = (st_q.prv == PRIV_S);
                        st_d.stval  = tval_val;
                        st_d.sepc   = ev_pc;
                        st_d.prv    = PRIV_S;
                    end else begin
                        st_d.mcause = cause_val;
                        st_d.mpie   = st_q.mie;
                        st_d.mie    = 1'b0;
                        st_d.mpp    = st_q.prv;
                        st_d.mtval  = tval_val;
                        st_d.mepc   = ev_pc;
                        st_d.prv    = PRIV_M;
                    end
                end
                EV_MRET: begin
                    st_d.redir = 1'b1;
                    st_d.npc   = tgt_pc;
                    st_d.mie   = st_q.mpie;
                    st_d.mpie  = 1'b1;
                    st_d.prv   = st_q.mpp;
                    st_d.mpp   = LOW_PRV;
                    if (st_q.mpp != PRIV_M) st_d.mprv = 1'b0;
                end
                EV_SRET: begin
                    if (HAS_S) begin
                        st_d.redir = 1'b1;
                        st_d.npc   = tgt_pc;
                        st_d.sie   = st_q.spie;
                        st_d.spie  = 1'b1;
                        st_d.prv   = st_q.spp ? PRIV_S : PRIV_U;
                        st_d.spp   = 1'b0;
                        st_d.mprv  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.prv <= PRIV_M;
            st_q.mpp <= LOW_PRV;
        end else begin
            st_q <= st_d;
        end
    end

    assign priv     = st_q.prv;
    assign st_mie   = st_q.mie;
    assign st_mpie  = st_q.mpie;
    assign st_mpp   = st_q.mpp;
    assign st_sie   = st_q.sie;
    assign st_spie  = st_q.spie;
    assign st_spp   = st_q.spp;
    assign st_mprv  = st_q.mprv;
    assign mcause   = st_q.mcause;
    assign mepc     = st_q.mepc;
    assign mtval    = st_q.mtval;
    assign scause   = st_q.scause;
    assign sepc     = st_q.sepc;
    assign stval    = st_q.stval;
    assign redirect = st_q.redir;
    assign next_pc  = st_q.npc;

    // R3
    no_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_TRAP) |=> (priv >= $past(priv)));

    // R4
    mtrap_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_TRAP && !tgt_is_s) |=>
        (priv == PRIV_M && !st_mie && st_mpie == $past(st_mie)
         && mepc == $past(ev_pc) && st_mpp == $past(priv)));

    // R5
    strap_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_TRAP && tgt_is_s) |=>
        (priv == PRIV_S && !st_sie && st_spie == $past(st_sie)
         && sepc == $past(ev_pc) && $stable(mepc)));

    // R7
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_MRET) |=>
        (st_mpie && st_mie == $past(st_mpie) && priv == $past(st_mpp)));

    // R9
    mprv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind == EV_MRET || ev_kind == EV_SRET)) |=>
        (priv == PRIV_M || !st_mprv));

    // R10
    redir_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (next_pc[0] == 1'b0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !mprv_set) |=>
        (!redirect && $stable(priv) && $stable(st_mpp) && $stable(st_mie)
         && $stable(st_sie) && $stable(mepc) && $stable(sepc)));

endmodule

// File: tb/sim_trap_seq.sv
module sim_trap_seq;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int CODE_W     = 5;
    localparam int NVEC       = 15;
    localparam int WDOG       = 5000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ev_valid;
    logic [1:0]        ev_kind;
    logic              ev_intr;
    logic [CODE_W-1:0] ev_code;
    logic [31:0]       ev_pc;
    logic              ev_tval_valid;
    logic [31:0]       ev_tval;
    logic [31:0]       deleg_mask;
    logic [31:0]       mtvec_base;
    logic [31:0]       stvec_base;
    logic              mprv_set;
    logic [1:0]        priv;
    logic              st_mie, st_mpie, st_sie, st_spie, st_spp, st_mprv;
    logic [1:0]        st_mpp;
    logic [31:0]       mcause, mepc, mtval, scause, sepc, stval, next_pc;
    logic              redirect;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_seq #(.XLEN(XLEN), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_intr(ev_intr), .ev_code(ev_code), .ev_pc(ev_pc),
        .ev_tval_valid(ev_tval_valid), .ev_tval(ev_tval),
        .deleg_mask(deleg_mask), .mtvec_base(mtvec_base),
        .stvec_base(stvec_base), .mprv_set(mprv_set), .priv(priv),
        .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp),
        .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp),
        .st_mprv(st_mprv), .mcause(mcause), .mepc(mepc), .mtval(mtval),
        .scause(scause), .sepc(sepc), .stval(stval),
        .redirect(redirect), .next_pc(next_pc)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        intr;
        logic [4:0]  code;
        logic [31:0] pc;
        logic        tvv;
        logic [31:0] tv;
        logic [31:0] mask;
        logic [1:0]  e_priv;
        logic        e_mie;
        logic        e_mpie;
        logic [1:0]  e_mpp;
        logic        e_sie;
        logic        e_spie;
        logic        e_spp;
        logic [31:0] e_npc;
        logic [31:0] e_mcause;
        logic [31:0] e_mepc;
        logic [31:0] e_mtval;
        logic [31:0] e_scause;
        logic [31:0] e_sepc;
        logic [31:0] e_stval;
    } vec_t;

    // one chain of events from reset; each row expects the state built so far
    localparam vec_t VECS [NVEC] = '{
        '{2'b01,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,32'h0,   32'h0,32'h0,32'h0,32'h0,32'h0,32'h0},
        '{2'b01,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,32'h0,   32'h0,32'h0,32'h0,32'h0,32'h0,32'h0},
        '{2'b00,1'b0,5'd2,32'h100,1'b1,32'hAB,  32'h4,  2'd1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,32'h2000,32'h0,32'h0,32'h0,32'h2,32'h100,32'hAB},
        '{2'b00,1'b0,5'd3,32'h204,1'b1,32'h77,  32'h4,  2'd3,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,32'h1000,32'h3,32'h204,32'h77,32'h2,32'h100,32'hAB},
        '{2'b00,1'b1,5'd5,32'h300,1'b0,32'hDEAD,32'h20, 2'd3,1'b0,1'b0,2'd3,1'b0,1'b0,1'b0,32'h1000,32'h80000005,32'h300,32'h0,32'h2,32'h100,32'hAB},
        '{2'b01,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,32'h300, 32'h80000005,32'h300,32'h0,32'h2,32'h100,32'hAB},
        '{2'b01,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,32'h300, 32'h80000005,32'h300,32'h0,32'h2,32'h100,32'hAB},
        '{2'b00,1'b0,5'd8,32'h401,1'b1,32'h55,  32'h100,2'd1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,32'h2000,32'h80000005,32'h300,32'h0,32'h8,32'h401,32'h55},
        '{2'b10,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,32'h400, 32'h80000005,32'h300,32'h0,32'h8,32'h401,32'h55},
        '{2'b00,1'b0,5'd1,32'h500,1'b0,32'hFF,  32'h2,  2'd1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,32'h2000,32'h80000005,32'h300,32'h0,32'h1,32'h500,32'h0},
        '{2'b00,1'b0,5'd1,32'h504,1'b0,32'h0,   32'h2,  2'd1,1'b1,1'b1,2'd0,1'b0,1'b0,1'b1,32'h2000,32'h80000005,32'h300,32'h0,32'h1,32'h504,32'h0},
        '{2'b10,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd1,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,32'h504, 32'h80000005,32'h300,32'h0,32'h1,32'h504,32'h0},
        '{2'b10,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b1,1'b1,2'd0,1'b1,1'b1,1'b0,32'h504, 32'h80000005,32'h300,32'h0,32'h1,32'h504,32'h0},
        '{2'b00,1'b0,5'd1,32'h600,1'b0,32'h0,   32'h2,  2'd1,1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,32'h2000,32'h80000005,32'h300,32'h0,32'h1,32'h600,32'h0},
        '{2'b10,1'b0,5'd0,32'h0,  1'b0,32'h0,   32'h0,  2'd0,1'b1,1'b1,2'd0,1'b1,1'b1,1'b0,32'h600, 32'h80000005,32'h300,32'h0,32'h1,32'h600,32'h0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fire(input logic [1:0] kind, input logic intr,
                        input logic [4:0] code, input logic [31:0] pc,
                        input logic tvv, input logic [31:0] tv,
                        input logic [31:0] mask, input logic valid);
        @(negedge clk);
        ev_valid = valid; ev_kind = kind; ev_intr = intr; ev_code = code;
        ev_pc = pc; ev_tval_valid = tvv; ev_tval = tv; deleg_mask = mask;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic pulse_mprv();
        @(negedge clk);
        mprv_set = 1'b1;
        @(negedge clk);
        mprv_set = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; ev_valid = 1'b0; ev_kind = 2'b11; ev_intr = 1'b0;
        ev_code = '0; ev_pc = '0; ev_tval_valid = 1'b0; ev_tval = '0;
        deleg_mask = '0; mprv_set = 1'b0;
        mtvec_base = 32'h0000_1003;
        stvec_base = 32'h0000_2002;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "priv", {30'd0, priv}, 32'd3);
        chk("R1", "mpp", {30'd0, st_mpp}, 32'd0);
        chk("R1", "enables", {26'd0, st_mie, st_mpie, st_sie, st_spie, st_spp, st_mprv}, 32'd0);
        chk("R1", "mcause|mepc|mtval", mcause | mepc | mtval, 32'd0);
        chk("R1", "scause|sepc|stval", scause | sepc | stval, 32'd0);
        chk("R1", "redirect", {31'd0, redirect}, 32'd0);

        // R2 R3 R4 R5 R6 R7 R8 R10: event chain
        for (int i = 0; i < NVEC; i++) begin
            fire(VECS[i].kind, VECS[i].intr, VECS[i].code, VECS[i].pc,
                 VECS[i].tvv, VECS[i].tv, VECS[i].mask, 1'b1);
            chk("R2/R3", $sformatf("row%0d priv", i), {30'd0, priv}, {30'd0, VECS[i].e_priv});
            chk("R4/R7", $sformatf("row%0d mie/mpie/mpp", i), {28'd0, st_mie, st_mpie, st_mpp},
                {28'd0, VECS[i].e_mie, VECS[i].e_mpie, VECS[i].e_mpp});
            chk("R5/R8", $sformatf("row%0d sie/spie/spp", i), {29'd0, st_sie, st_spie, st_spp},
                {29'd0, VECS[i].e_sie, VECS[i].e_spie, VECS[i].e_spp});
            chk("R10", $sformatf("row%0d redirect", i), {31'd0, redirect}, 32'd1);
            chk("R10", $sformatf("row%0d next_pc", i), next_pc, VECS[i].e_npc);
            chk("R4", $sformatf("row%0d mcause", i), mcause, VECS[i].e_mcause);
            chk("R4", $sformatf("row%0d mepc", i), mepc, VECS[i].e_mepc);
            chk("R6", $sformatf("row%0d mtval", i), mtval, VECS[i].e_mtval);
            chk("R5", $sformatf("row%0d scause", i), scause, VECS[i].e_scause);
            chk("R5", $sformatf("row%0d sepc", i), sepc, VECS[i].e_sepc);
            chk("R6", $sformatf("row%0d stval", i), stval, VECS[i].e_stval);
            @(negedge clk);
            chk("R10", $sformatf("row%0d redirect drop", i), {31'd0, redirect}, 32'd0);
        end

        // R1 reset returns everything to its initial state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "priv after reapply", {30'd0, priv}, 32'd3);
        chk("R1", "sepc after reapply", sepc, 32'd0);

        // R11 kind 11 is ignored
        fire(2'b11, 1'b1, 5'd4, 32'h900, 1'b1, 32'h9, 32'hFFFF_FFFF, 1'b1);
        chk("R11", "redirect kind11", {31'd0, redirect}, 32'd0);
        chk("R11", "priv kind11", {30'd0, priv}, 32'd3);
        chk("R11", "mepc kind11", mepc, 32'd0);
        // R11 trap fields with strobe low
        fire(2'b00, 1'b0, 5'd4, 32'h904, 1'b1, 32'h9, 32'h0, 1'b0);
        chk("R11", "redirect idle", {31'd0, redirect}, 32'd0);
        chk("R11", "mepc idle", mepc, 32'd0);
        chk("R11", "mpp idle", {30'd0, st_mpp}, 32'd0);

        // R9 MPRV set, kept on return to machine, dropped on return to user
        pulse_mprv();
        chk("R9", "mprv set", {31'd0, st_mprv}, 32'd1);
        fire(2'b00, 1'b0, 5'd0, 32'h777, 1'b0, 32'h0, 32'h0, 1'b1);
        chk("R9", "mprv kept by trap", {31'd0, st_mprv}, 32'd1);
        chk("R4", "mpp from machine", {30'd0, st_mpp}, 32'd3);
        fire(2'b01, 1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
        chk("R7", "priv mret to M", {30'd0, priv}, 32'd3);
        chk("R9", "mprv kept at M", {31'd0, st_mprv}, 32'd1);
        chk("R10", "mret odd epc", next_pc, 32'h776);
        fire(2'b01, 1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
        chk("R7", "priv mret to U", {30'd0, priv}, 32'd0);
        chk("R9", "mprv dropped at U", {31'd0, st_mprv}, 32'd0);
        pulse_mprv();
        fire(2'b10, 1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
        chk("R8", "priv sret spp0", {30'd0, priv}, 32'd0);
        chk("R9", "mprv dropped by sret", {31'd0, st_mprv}, 32'd0);

        finish_run();
    end

endmodule